// File: doc/BRIEF.md
# UTOPIA Level 1 Transmit Link Controller

This block drives the transmit side of a UTOPIA Level 1 link-layer (master) port. User logic holds one cell at a time in a buffer of 27 sixteen-bit words. The block reads that buffer through a word address and a one-cycle read strobe. It sends the words to the PHY as bytes on an 8-bit bus, high byte first. It drives an active-low transmit enable and a start-of-cell marker, and it uses the PHY's cell-available flag to decide when a cell may start.

A mode pin selects the cell length. When the pin is high, all 54 buffer bytes go to the PHY unchanged. When it is low, the low byte of the third word, which is the sixth byte of the cell, is dropped, so a 53-byte cell goes out. In that mode the block reads two words on consecutive cycles so the first payload byte follows the fifth header byte without a gap. All logic runs on the transmit clock.

Top module: `utopia_tx_link`

## Requirements
- R1: A cell starts only after a clock edge at which `cell_rdy` and `phy_space` are both high. The next cycle is a preparatory cycle: `rd_en` is 1, `rd_addr` is 0 and `tx_en_n` is still 1. While either input is low in the idle state, nothing starts.
- R2: The cycle after the preparatory cycle carries the first byte. In that cycle `tx_en_n` is 0, `tx_soc` is 1 and `tx_byte` is the high byte of word 0. `tx_soc` is 1 on no other cycle.
- R3: Once a cell has started, every byte of it is sent on consecutive cycles with `tx_en_n` at 0. Dropping `cell_rdy` or `phy_space` during the cell has no effect.
- R4: `rd_en` is high for one cycle per word read. The word on `rd_word` is taken at the clock edge that ends that cycle, and `rd_addr` advances at the same edge. `rd_addr` does not change on any other edge.
- R5: `rd_addr` counts 0 to 26 within a cell and returns to 0 after word 26 is read.
- R6: With `mode54` at 0, a cell is 53 bytes long. Byte i of the buffer is bits [15:8] of word i/2 when i is even and bits [7:0] when i is odd. Byte 5 is skipped. Word 3 is read in the cycle right after word 2, so byte 4 is followed directly by byte 6.
- R7: With `mode54` at 1, a cell is 54 bytes long, in the same byte order. `rd_en` is never high on two consecutive cycles.
- R8: `cell_rdy` and `phy_space` are sampled in the cycle that carries the second-to-last byte. If both are high, word 0 of the next cell is read during the last byte, and the next cell's first byte follows with no idle cycle.
- R9: If either input was low at that sample, `tx_en_n` returns to 1 in the cycle after the last byte.
- R10: While `rst` is high, all state is cleared and held: `tx_en_n` is 1, `rd_en` is 0, `rd_addr` is 0 and `tx_byte` is 0, even in the middle of a cell.
- R11: While `tx_en_n` is 1, `tx_byte` is 0 and `tx_soc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| mode54 | input | 1 | 1: send 54-byte cells; 0: send 53-byte cells, dropping byte 5 |
| cell_rdy | input | 1 | The user buffer holds a complete cell |
| phy_space | input | 1 | The PHY can accept a cell |
| rd_en | output | 1 | Buffer read strobe, one cycle per word |
| rd_addr | output | AW (5) | Word address in the cell buffer |
| rd_word | input | 16 | Buffer word at `rd_addr` |
| tx_en_n | output | 1 | Transmit enable to the PHY, active low |
| tx_soc | output | 1 | Start-of-cell marker |
| tx_byte | output | 8 | Transmit byte to the PHY |

## Verification
The assertions assume that `mode54` stays constant while a cell is being sent. They also assume that the buffer presents the word for `rd_addr` during every cycle in which `rd_en` is high. The bench changes `mode54` only while the block is idle, with `cell_rdy` low. Its buffer model derives `rd_word` directly from `rd_addr` and from a cell counter. That counter advances at the edge where word 26 is read, so every transmitted byte can be predicted from its cell number and its position in the cell. Readiness and space are dropped and restored during a cell only at fixed byte positions far from the sample point of R8.

// File: rtl/utopia_tx_link.sv
module utopia_tx_link #(
  parameter int WORDS = 27,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode54,
  input  logic          cell_rdy,
  input  logic          phy_space,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_word,
  output logic          tx_en_n,
  output logic          tx_soc,
  output logic [7:0]    tx_byte
);

  localparam int NBYTES = 2 * WORDS;
  localparam int BW     = $clog2(NBYTES);
  localparam logic [BW-1:0] LAST_B  = BW'(NBYTES - 1);
  localparam logic [BW-1:0] PLAST_B = BW'(NBYTES - 2);
  localparam logic [BW-1:0] HOP_B   = BW'(4);
  localparam logic [BW-1:0] LAND_B  = BW'(6);
  localparam logic [AW-1:0] LAST_W  = AW'(WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_SEND} st_t;

  st_t         st;
  logic [BW-1:0] bcnt;
  logic [BW-1:0] nb;
  logic [15:0] wreg;
  logic        cont;
  logic        sending;

  assign sending = (st == S_SEND);
  assign nb      = (bcnt == HOP_B && !mode54) ? LAND_B : bcnt + BW'(1);
  assign rd_en   = (st == S_PRE) || (sending && ((bcnt == LAST_B) ? cont : !nb[0]));
  assign tx_en_n = !sending;
  assign tx_soc  = sending && (bcnt == '0);
  assign tx_byte = sending ? (bcnt[0] ? wreg[7:0] : wreg[15:8]) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      wreg    <= '0;
      cont    <= 1'b0;
      rd_addr <= '0;
    end else begin
      if (rd_en) begin
        wreg    <= rd_word;
        rd_addr <= (rd_addr == LAST_W) ? '0 : rd_addr + AW'(1);
      end
      case (st)
        S_IDLE: if (cell_rdy && phy_space) st <= S_PRE;
        S_PRE: begin
          st   <= S_SEND;
          bcnt <= '0;
        end
        S_SEND: begin
          if (bcnt == PLAST_B) cont <= cell_rdy && phy_space;
          if (bcnt == LAST_B) begin
            bcnt <= '0;
            st   <= cont ? S_SEND : S_IDLE;
          end else begin
            bcnt <= nb;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/utopia_tx_link_chk.sv
module utopia_tx_link_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          mode54,
  input logic          cell_rdy,
  input logic          phy_space,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          tx_en_n,
  input logic          tx_soc,
  input logic [7:0]    tx_byte
);

  AST_PREP_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst) (rd_en && tx_en_n) |-> $past(cell_rdy && phy_space)); // R1
  AST_START_AFTER_READ: assert property (@(posedge clk) disable iff (rst) $fell(tx_en_n) |-> $past(rd_en)); // R1
  AST_SOC_ENABLED: assert property (@(posedge clk) disable iff (rst) tx_soc |-> (!tx_en_n && rd_addr == AW'(1))); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) !$past(rd_en) |-> $stable(rd_addr)); // R4
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) rd_addr <= AW'(26)); // R5
  AST_CELL_WHOLE: assert property (@(posedge clk) disable iff (rst) $rose(tx_en_n) |-> ($past(rd_addr) == '0 && !$past(rd_en))); // R3
  AST_NO_PAIR_54: assert property (@(posedge clk) disable iff (rst) (mode54 && $past(mode54) && $past(rd_en)) |-> !rd_en); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) tx_en_n |-> (tx_byte == 8'h00 && !tx_soc)); // R11

endmodule

bind utopia_tx_link utopia_tx_link_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .mode54(mode54), .cell_rdy(cell_rdy), .phy_space(phy_space),
  .rd_en(rd_en), .rd_addr(rd_addr), .tx_en_n(tx_en_n), .tx_soc(tx_soc), .tx_byte(tx_byte)
);

// File: tb/test_utopia_tx_link.sv
module test_utopia_tx_link;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {mode54, stop_by_space, cells[1:0]}
  localparam bit [3:0] VEC [0:NV-1] = '{4'b1_0_01, 4'b0_0_01, 4'b1_1_10,
                                        4'b0_1_11, 4'b0_0_10, 4'b1_0_11};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode54 = 1'b1;
  logic       cell_rdy = 1'b0;
  logic       phy_space = 1'b0;
  logic       rd_en;
  logic [4:0] rd_addr;
  logic [15:0] rd_word;
  logic       tx_en_n;
  logic       tx_soc;
  logic [7:0] tx_byte;

  int checks = 0;
  int errors = 0;
  logic [1:0] bcid;
  logic [1:0] ecid;
  int exp_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) bcid <= 2'd0;
    else if (rd_en && rd_addr == 5'd26) bcid <= bcid + 2'd1;
  end
  assign rd_word = {bcid, rd_addr, 1'b0, bcid, rd_addr, 1'b1};

  utopia_tx_link i_utopia_tx_link (
    .clk(clk), .rst(rst), .mode54(mode54), .cell_rdy(cell_rdy), .phy_space(phy_space),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_word(rd_word),
    .tx_en_n(tx_en_n), .tx_soc(tx_soc), .tx_byte(tx_byte)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(tx_en_n == 1'b1, req, "tx_en_n idle", int'(tx_en_n), 1);
    chk(tx_soc == 1'b0, req, "tx_soc idle", int'(tx_soc), 0);
    chk(tx_byte == 8'h00, req, "tx_byte idle", int'(tx_byte), 0);
    chk(rd_en == 1'b0, req, "rd_en idle", int'(rd_en), 0);
    chk(rd_addr == 5'd0, req, "rd_addr idle", int'(rd_addr), 0);
  endtask

  task automatic run_vec(input bit m, input bit by_space, input int n);
    mode54 = m;
    cell_rdy = 1'b1;
    phy_space = 1'b1;
    @(negedge clk);
    chk(rd_en == 1'b1, "R1", "rd_en prep", int'(rd_en), 1);
    chk(tx_en_n == 1'b1, "R1", "tx_en_n prep", int'(tx_en_n), 1);
    chk(rd_addr == 5'd0, "R1", "rd_addr prep", int'(rd_addr), 0);
    exp_addr = 1;
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 54; b++) begin
        bit last;
        bit erd;
        int nb;
        if (!m && b == 5) continue;
        @(negedge clk);
        last = (k == n - 1);
        nb = (!m && b == 4) ? 6 : b + 1;
        erd = (b == 53) ? !last : (nb % 2 == 0);
        chk(tx_en_n == 1'b0, "R3", "tx_en_n in cell", int'(tx_en_n), 0);
        chk(tx_soc == (b == 0), "R2", "tx_soc", int'(tx_soc), int'(b == 0));
        chk(tx_byte == {ecid, 6'(b)}, m ? "R7" : "R6", "tx_byte", int'(tx_byte), int'({ecid, 6'(b)}));
        chk(rd_en == erd, (b == 53) ? "R8" : "R4", "rd_en", int'(rd_en), int'(erd));
        chk(rd_addr == 5'(exp_addr), "R5", "rd_addr", int'(rd_addr), exp_addr);
        if (erd) exp_addr = (exp_addr + 1) % 27;
        if (b == 10) begin
          if (!last) begin
            cell_rdy = 1'b0;
            phy_space = 1'b0;
          end else if (by_space) phy_space = 1'b0;
          else cell_rdy = 1'b0;
        end
        if (b == 30 && !last) begin
          cell_rdy = 1'b1;
          phy_space = 1'b1;
        end
      end
      ecid = ecid + 2'd1;
    end
    @(negedge clk);
    chk_idle("R9");
    repeat (3) begin
      @(negedge clk);
      chk_idle("R1");
    end
    cell_rdy = 1'b0;
    phy_space = 1'b0;
  endtask

  initial begin
    ecid = 2'd0;
    repeat (3) @(negedge clk);
    chk_idle("R10");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R11");

    cell_rdy = 1'b1;
    phy_space = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk_idle("R1");
    end
    cell_rdy = 1'b0;
    phy_space = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk_idle("R1");
    end
    phy_space = 1'b0;

    for (int v = 0; v < NV; v++) run_vec(VEC[v][3], VEC[v][2], int'(VEC[v][1:0]));

    mode54 = 1'b1;
    cell_rdy = 1'b1;
    phy_space = 1'b1;
    repeat (12) @(negedge clk);
    chk(tx_en_n == 1'b0, "R10", "tx_en_n before reset", int'(tx_en_n), 0);
    rst = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk_idle("R10");
    end
    cell_rdy = 1'b0;
    phy_space = 1'b0;
    rst = 1'b0;
    ecid = 2'd0;
    @(negedge clk);
    chk_idle("R10");
    run_vec(1'b0, 1'b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule